// File: doc/BRIEF.md
# Transmit Descriptor Ring Run Controller

This block is the control sequencer for the transmit side of a descriptor-driven DMA engine. Software programs a 32-bit control word that holds three fields. The first is a run/halt command bit. The second enables overlapping two frames. The third must be written as one before a run command is honoured. From these fields the block runs a three-state process: Stopped, Running and Suspended. It fetches descriptors through a request/response port. Each response returns an ownership flag, an error flag and the address of the following descriptor. The block hands owned descriptors to a transmitter with a start/done handshake and returns each completed descriptor with a one-cycle writeback strobe.

The block tracks two positions. The fetch position is the next descriptor to read. The current position is the descriptor after the last one that completed. A halt request lets every frame already handed to the transmitter finish. The current position is then kept, so that the next run command resumes from it. A descriptor that software has not handed over suspends the process and raises a sticky status flag. A poll pulse retries the same descriptor. The bus master datapath, data movement and frame formatting sit outside this block.

Top module: `txring_run_ctrl`

## Requirements
- R1: The control word is written when `cfg_wr` is high and `cfg_addr` equals 0x18. In that word, bit 13 is the run command, bit 2 is the overlap enable and bit 21 is the must-be-one bit. A write to any other offset has no effect. After reset all three bits are zero, the process is Stopped and `unavail_flag` is low.
- R2: `tx_state` encodes the process state as 2'b00 Stopped, 2'b01 Running and 2'b10 Suspended. No other code ever appears.
- R3: A write that changes bit 13 from 0 to 1 and also carries bit 21 set moves the process from Stopped to Running. The same change in Running or Suspended is ignored, including while a halt is still draining. Without bit 21 the change is also ignored.
- R4: On the first run after reset, the first descriptor fetch uses `list_base`. Every fetch is a one-cycle `desc_req` pulse with `desc_addr`, and at most one fetch is outstanding at a time.
- R5: A response with `desc_owned` low (and `desc_err` low) moves the process to Suspended and sets `unavail_flag`. No frame is started for that descriptor.
- R6: A response with `desc_err` high, meaning the descriptor could not be acquired, moves the process to Suspended and leaves `unavail_flag` unchanged.
- R7: A write that changes bit 13 from 1 to 0 in Running or Suspended stops new fetches. A response that arrives during the halt is discarded. Every frame already started completes. The process then enters Stopped with no frame outstanding. The same change while Stopped has no effect.
- R8: On a later run command, the first fetch uses the saved current position. This is the next-descriptor address of the last completed frame, or `list_base` if no frame has completed since reset.
- R9: With the overlap bit clear, at most one frame is outstanding between `frm_start` and its writeback. With the bit set, up to two frames are outstanding.
- R10: In Suspended, a `tx_poll` pulse re-fetches the same descriptor. An owned response returns the process to Running and starts that frame. A non-owned response keeps the process Suspended.
- R11: `unavail_flag` stays set until a cycle with `unavail_clr` high. When the flag is set and cleared in the same cycle, setting wins.
- R12: One cycle after `frm_done`, `wb_strobe` pulses for one cycle with `wb_addr` equal to the oldest outstanding descriptor. In that same cycle, `cur_pos` shows that descriptor's next address.
- R13: An owned response produces a one-cycle `frm_start`, one cycle after the response, with `frm_desc` equal to the fetched address. Frames start in list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_addr | input | RAW | Control write byte offset |
| cfg_wdata | input | 32 | Control write data |
| list_base | input | AW | Base address of the transmit list |
| tx_poll | input | 1 | Retry pulse while Suspended |
| unavail_clr | input | 1 | Clears the unavailable flag |
| desc_req | output | 1 | Descriptor fetch request pulse |
| desc_addr | output | AW | Address of the descriptor fetched |
| desc_vld | input | 1 | Descriptor response valid |
| desc_owned | input | 1 | Descriptor owned by the DMA engine |
| desc_err | input | 1 | Descriptor could not be acquired |
| desc_next | input | AW | Next-descriptor address from the response |
| frm_start | output | 1 | Frame handoff pulse to the transmitter |
| frm_desc | output | AW | Descriptor of the frame handed off |
| frm_done | input | 1 | Oldest outstanding frame completed |
| wb_strobe | output | 1 | Ownership writeback pulse |
| wb_addr | output | AW | Descriptor returned to software |
| tx_state | output | 2 | Process state |
| cur_pos | output | AW | Current (saved) descriptor position |
| unavail_flag | output | 1 | Sticky buffer-unavailable status |

## Verification
The bound checker watches several properties on every cycle. It checks that the state code is legal and that fetch pulses never repeat back to back. It checks that a fetch never starts while a frame is outstanding when overlap is off. It checks that a non-owned or failed response lands in Suspended, that the flag is sticky, and that each writeback and frame start follows its cause. It also checks that Stopped is entered only once the transmitter is drained.

Some behaviours need the bench's scenarios. These are the order of descriptors across wraps of the ring and the position saved across a halt and a resume. They also include the effect of poll on a suspended list, and the rejection of run commands that come during a halt. The bench also sweeps response latency, transmitter delay and the overlap bit to show when two frames overlap.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [1:0] {
    TXS_STOP = 2'b00,
    TXS_RUN  = 2'b01,
    TXS_SUSP = 2'b10
  } txs_e;

  localparam int CMD_BIT = 13;
  localparam int OVL_BIT = 2;
  localparam int ARM_BIT = 21;

  // number of frames allowed between handoff and writeback
  function automatic int unsigned frame_limit(input logic ovl, input int unsigned depth);
    return ovl ? depth : 32'd1;
  endfunction

  // circular pointer step
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/txr_ctlreg.sv
module txr_ctlreg #(
  parameter int RAW = 8,
  parameter logic [RAW-1:0] OFS = 'h18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [RAW-1:0] addr,
  input  logic [31:0]    wdata,
  output logic           ovl_q,
  output logic           start_evt,
  output logic           stop_evt
);
  import txr_pkg::*;

  logic hit;
  logic cmd_q;
  logic arm_q;
  logic unused_wbits;

  assign hit       = wr && (addr == OFS);
  assign start_evt = hit && wdata[CMD_BIT] && !cmd_q && wdata[ARM_BIT];
  assign stop_evt  = hit && !wdata[CMD_BIT] && cmd_q;
  assign unused_wbits = ^{wdata[31:22], wdata[20:14], wdata[12:3], wdata[1:0], arm_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      ovl_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (hit) begin
      cmd_q <= wdata[CMD_BIT];
      ovl_q <= wdata[OVL_BIT];
      arm_q <= wdata[ARM_BIT];
    end
  end

endmodule

// File: rtl/txr_inflight.sv
module txr_inflight #(
  parameter int AW    = 32,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [AW-1:0] push_next,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [AW-1:0] head_next,
  output logic [CW-1:0] cnt
);
  import txr_pkg::*;

  logic [AW-1:0] addr_q [DEPTH];
  logic [AW-1:0] next_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign head_addr = addr_q[rd_ptr];
  assign head_next = next_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        next_q[i] <= '0;
      end
    end else begin
      if (push) begin
        addr_q[wr_ptr] <= push_addr;
        next_q[wr_ptr] <= push_next;
        wr_ptr <= PW'(wrap_inc(32'(wr_ptr), DEPTH));
      end
      if (pop) rd_ptr <= PW'(wrap_inc(32'(rd_ptr), DEPTH));
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/txring_run_ctrl.sv
module txring_run_ctrl #(
  parameter int AW     = 32,
  parameter int RAW    = 8,
  parameter logic [RAW-1:0] CTRL_OFS = 'h18,
  parameter int QDEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  input  logic [AW-1:0]  list_base,
  input  logic           tx_poll,
  input  logic           unavail_clr,
  output logic           desc_req,
  output logic [AW-1:0]  desc_addr,
  input  logic           desc_vld,
  input  logic           desc_owned,
  input  logic           desc_err,
  input  logic [AW-1:0]  desc_next,
  output logic           frm_start,
  output logic [AW-1:0]  frm_desc,
  input  logic           frm_done,
  output logic           wb_strobe,
  output logic [AW-1:0]  wb_addr,
  output logic [1:0]     tx_state,
  output logic [AW-1:0]  cur_pos,
  output logic           unavail_flag
);
  import txr_pkg::*;

  localparam int CW = $clog2(QDEPTH + 1);

  // control word events
  logic ovl_q, start_evt, stop_evt;

  // in-flight bookkeeping
  logic [AW-1:0] head_addr, head_next;
  logic [CW-1:0] inflight_cnt;

  // process state
  txs_e          state;
  logic          stop_pend, fetch_busy, has_run;
  logic [AW-1:0] fetch_ptr;

  // named events
  logic limit_ok, rsp_take, rsp_use, push, pop, launch, drained, not_owned;

  txr_ctlreg #(.RAW(RAW), .OFS(CTRL_OFS)) u_reg (
    .clk, .rst_n,
    .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .ovl_q, .start_evt, .stop_evt
  );

  txr_inflight #(.AW(AW), .DEPTH(QDEPTH)) u_fly (
    .clk, .rst_n,
    .push, .push_addr(fetch_ptr), .push_next(desc_next),
    .pop, .head_addr, .head_next, .cnt(inflight_cnt)
  );

  assign limit_ok  = 32'(inflight_cnt) < frame_limit(ovl_q, QDEPTH);
  assign rsp_take  = fetch_busy && desc_vld;
  assign rsp_use   = rsp_take && !stop_pend;
  assign push      = rsp_use && !desc_err && desc_owned;
  assign not_owned = rsp_use && !desc_err && !desc_owned;
  assign pop       = frm_done && (inflight_cnt != '0);
  assign launch    = !stop_pend && !fetch_busy && limit_ok &&
                     ((state == TXS_RUN) || (state == TXS_SUSP && tx_poll));
  assign drained   = stop_pend && (inflight_cnt == '0) && !fetch_busy;

  assign tx_state = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= TXS_STOP;
      stop_pend    <= 1'b0;
      fetch_busy   <= 1'b0;
      has_run      <= 1'b0;
      fetch_ptr    <= '0;
      cur_pos      <= '0;
      unavail_flag <= 1'b0;
      desc_req     <= 1'b0;
      desc_addr    <= '0;
      frm_start    <= 1'b0;
      frm_desc     <= '0;
      wb_strobe    <= 1'b0;
      wb_addr      <= '0;
    end else begin
      desc_req  <= launch;
      frm_start <= push;
      wb_strobe <= pop;

      if (launch) begin
        fetch_busy <= 1'b1;
        desc_addr  <= fetch_ptr;
      end
      if (rsp_take) fetch_busy <= 1'b0;

      if (push) begin
        frm_desc  <= fetch_ptr;
        fetch_ptr <= desc_next;
        state     <= TXS_RUN;
      end else if (rsp_use) begin
        state <= TXS_SUSP;
      end

      if (not_owned)        unavail_flag <= 1'b1;
      else if (unavail_clr) unavail_flag <= 1'b0;

      if (pop) begin
        wb_addr <= head_addr;
        cur_pos <= head_next;
      end

      if (start_evt && state == TXS_STOP) begin
        state   <= TXS_RUN;
        has_run <= 1'b1;
        if (!has_run) begin
          fetch_ptr <= list_base;
          cur_pos   <= list_base;
        end else begin
          fetch_ptr <= cur_pos;
        end
      end

      if (stop_evt && state != TXS_STOP) stop_pend <= 1'b1;

      if (drained) begin
        state     <= TXS_STOP;
        stop_pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/txring_run_ctrl_chk.sv
module txring_run_ctrl_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    state,
  input logic [CW-1:0] cnt,
  input logic          ovl,
  input logic          desc_req,
  input logic          desc_vld,
  input logic          desc_owned,
  input logic          desc_err,
  input logic          rsp_take,
  input logic          stop_pend,
  input logic          flag,
  input logic          flag_clr,
  input logic          frm_done,
  input logic          frm_start,
  input logic          wb_strobe
);

  // R2
  a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);

  // R4
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req |=> !desc_req);

  // R7
  a_r7_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00) |-> (!desc_req && !frm_start));

  // R7
  a_r7_stop_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00 && $past(state) != 2'b00) |-> (cnt == '0));

  // R5
  a_r5_not_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !stop_pend && !desc_err && !desc_owned) |=> (flag && state == 2'b10));

  // R6
  a_r6_err_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !stop_pend && desc_err) |=> (state == 2'b10));

  // R9
  a_r9_single_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !$past(ovl)) |-> ($past(cnt) == '0));

  // R11
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  // R12
  a_r12_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_strobe |-> $past(frm_done));

  // R13
  a_r13_start_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> $past(desc_vld && desc_owned && !desc_err));

endmodule

bind txring_run_ctrl txring_run_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(tx_state), .cnt(inflight_cnt), .ovl(ovl_q),
  .desc_req(desc_req), .desc_vld(desc_vld), .desc_owned(desc_owned),
  .desc_err(desc_err), .rsp_take(rsp_take), .stop_pend(stop_pend),
  .flag(unavail_flag), .flag_clr(unavail_clr), .frm_done(frm_done),
  .frm_start(frm_start), .wb_strobe(wb_strobe)
);

// File: tb/txring_run_ctrl_tb.sv
module txring_run_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam logic [31:0] W_ARM = 32'h0020_0000;
  localparam logic [31:0] W_RUN = 32'h0000_2000;
  localparam logic [31:0] W_OVL = 32'h0000_0004;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [7:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic tx_poll, unavail_clr;
  logic desc_req; logic [31:0] desc_addr;
  logic desc_vld, desc_owned, desc_err; logic [31:0] desc_next;
  logic frm_start; logic [31:0] frm_desc;
  logic frm_done;
  logic wb_strobe; logic [31:0] wb_addr;
  logic [1:0] tx_state;
  logic [31:0] cur_pos;
  logic unavail_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  txring_run_ctrl u_dut (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .list_base(BASE),
    .tx_poll, .unavail_clr, .desc_req, .desc_addr, .desc_vld, .desc_owned,
    .desc_err, .desc_next, .frm_start, .frm_desc, .frm_done, .wb_strobe,
    .wb_addr, .tx_state, .cur_pos, .unavail_flag
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model
  bit own [8];
  bit rearm;
  logic [31:0] err_addr;
  int lat, dly, cur_ovl;
  int rsp_cnt; logic [31:0] pend_addr;
  logic [31:0] exp_ptr, last_next, last_req;
  int req_cnt, start_cnt, done_cnt, outst, max_out;
  logic [31:0] q_addr [16];
  int q_cyc [16];
  int wr_i, dn_i, wb_i;

  function automatic int didx(input logic [31:0] a);
    return int'(((a - BASE) >> 4) & 32'd7);
  endfunction
  function automatic logic [31:0] dnext(input logic [31:0] a);
    return BASE + 32'((didx(a) + 1) % 8) * 32'd16;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // descriptor responder, transmitter and monitor
  always @(negedge clk) begin
    cyc++;
    desc_vld  = 1'b0;
    frm_done  = 1'b0;
    if (!rst_n) begin
      rsp_cnt = 0; exp_ptr = BASE; last_next = BASE; outst = 0; max_out = 0;
      req_cnt = 0; start_cnt = 0; done_cnt = 0; wr_i = 0; dn_i = 0; wb_i = 0;
      last_req = 32'hFFFF_FFFF;
    end else begin
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          desc_vld   = 1'b1;
          desc_owned = own[didx(pend_addr)];
          desc_err   = (pend_addr == err_addr);
          desc_next  = dnext(pend_addr);
        end
      end
      if (desc_req) begin
        pend_addr = desc_addr; rsp_cnt = lat; req_cnt++; last_req = desc_addr;
      end
      if (frm_start) begin
        check(frm_desc == exp_ptr, "R13 frame order", frm_desc, exp_ptr);
        exp_ptr = dnext(exp_ptr);
        q_addr[wr_i % 16] = frm_desc; q_cyc[wr_i % 16] = cyc; wr_i++;
        outst++; start_cnt++;
        if (outst > max_out) max_out = outst;
        check(outst <= (cur_ovl != 0 ? 2 : 1), "R9 outstanding limit", 32'(outst), 32'(cur_ovl != 0 ? 2 : 1));
      end
      if (wb_strobe) begin
        check(wb_addr == q_addr[wb_i % 16], "R12 writeback address", wb_addr, q_addr[wb_i % 16]);
        check(cur_pos == dnext(wb_addr), "R12 position advance", cur_pos, dnext(wb_addr));
        last_next = dnext(wb_addr);
        if (!rearm) own[didx(wb_addr)] = 1'b0;
        wb_i++; outst--; done_cnt++;
      end
      if (dn_i < wr_i && cyc >= q_cyc[dn_i % 16] + dly) begin
        frm_done = 1'b1; dn_i++;
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr_ctl(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_state(input logic [1:0] s, input int n);
    for (int i = 0; i < n && tx_state != s; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic own_all(input bit v);
    for (int i = 0; i < 8; i++) own[i] = v;
  endtask

  task automatic pulse_poll();
    @(negedge clk); tx_poll = 1'b1;
    @(negedge clk); tx_poll = 1'b0;
  endtask

  initial begin
    int n;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tx_poll = 1'b0; unavail_clr = 1'b0;
    desc_vld = 1'b0; desc_owned = 1'b0; desc_err = 1'b0; desc_next = '0; frm_done = 1'b0;
    err_addr = 32'hFFFF_FFFF; lat = 1; dly = 2; cur_ovl = 0; rearm = 1'b1;
    own_all(1'b1);
    do_reset();

    // R1 / R2: reset state
    check(tx_state == 2'b00, "R2 reset state", 32'(tx_state), 0);
    check(unavail_flag == 1'b0, "R1 reset flag", 32'(unavail_flag), 0);
    check(desc_req == 1'b0, "R1 reset idle", 32'(desc_req), 0);

    // R1: other offset ignored
    wr_ctl(8'h14, W_ARM | W_RUN);
    repeat (3) @(negedge clk);
    check(tx_state == 2'b00 && req_cnt == 0, "R1 wrong offset ignored", 32'(tx_state), 0);
    // R3: run without must-be-one bit ignored
    wr_ctl(8'h18, W_RUN);
    repeat (3) @(negedge clk);
    check(tx_state == 2'b00 && req_cnt == 0, "R3 run without arm bit", 32'(tx_state), 0);
    wr_ctl(8'h18, 32'h0);

    // sweep: overlap x response latency x transmitter delay
    for (int o = 0; o < 2; o++) begin
      for (int l = 1; l <= 3; l++) begin
        for (int d = 1; d <= 6; d++) begin
          cur_ovl = o; lat = l; dly = d; rearm = 1'b1; err_addr = 32'hFFFF_FFFF;
          own_all(1'b1);
          do_reset();
          wr_ctl(8'h18, W_ARM | W_RUN | (o != 0 ? W_OVL : 32'h0));
          check(tx_state == 2'b01, "R3 run accepted", 32'(tx_state), 1);
          for (int i = 0; i < 400 && done_cnt < 10; i++) @(negedge clk);
          check(done_cnt >= 10, "R13 frames completed", 32'(done_cnt), 10);
          wr_ctl(8'h18, W_ARM | (o != 0 ? W_OVL : 32'h0));
          wait_state(2'b00, 200);
          check(tx_state == 2'b00, "R7 halt reaches Stopped", 32'(tx_state), 0);
          check(outst == 0, "R7 all frames completed", 32'(outst), 0);
          check(cur_pos == last_next, "R8 saved position", cur_pos, last_next);
          check(start_cnt == done_cnt, "R7 no frame lost", 32'(start_cnt), 32'(done_cnt));
          if (o == 0)
            check(max_out == 1, "R9 single frame", 32'(max_out), 1);
          else if (d >= l + 3)
            check(max_out == 2, "R9 overlapped frames", 32'(max_out), 2);
          // R8: resume from the saved position
          n = req_cnt;
          wr_ctl(8'h18, W_ARM | W_RUN);
          for (int i = 0; i < 20 && req_cnt == n; i++) @(negedge clk);
          check(last_req == last_next, "R8 resume address", last_req, last_next);
          wr_ctl(8'h18, W_ARM);
          wait_state(2'b00, 200);
          check(tx_state == 2'b00, "R7 second halt", 32'(tx_state), 0);
        end
      end
    end

    // R4 / R5 / R10 / R11: ownership failure and poll
    cur_ovl = 0; lat = 2; dly = 3; rearm = 1'b0; err_addr = 32'hFFFF_FFFF;
    own_all(1'b0); own[0] = 1'b1; own[1] = 1'b1; own[2] = 1'b1;
    do_reset();
    n = req_cnt;
    wr_ctl(8'h18, W_ARM | W_RUN);
    for (int i = 0; i < 20 && req_cnt == n; i++) @(negedge clk);
    check(last_req == BASE, "R4 first fetch at list base", last_req, BASE);
    wait_state(2'b10, 300);
    repeat (3) @(negedge clk);
    check(tx_state == 2'b10, "R5 suspended", 32'(tx_state), 2);
    check(unavail_flag == 1'b1, "R5 flag set", 32'(unavail_flag), 1);
    check(done_cnt == 3, "R5 frames before gap", 32'(done_cnt), 3);
    check(last_req == BASE + 32'd48, "R5 failed descriptor", last_req, BASE + 32'd48);
    n = req_cnt;
    pulse_poll();
    repeat (8) @(negedge clk);
    check(req_cnt == n + 1, "R10 poll refetches", 32'(req_cnt), 32'(n + 1));
    check(last_req == BASE + 32'd48, "R10 same descriptor", last_req, BASE + 32'd48);
    check(tx_state == 2'b10, "R10 still suspended", 32'(tx_state), 2);
    rearm = 1'b1; own_all(1'b1);
    n = start_cnt;
    pulse_poll();
    wait_state(2'b01, 20);
    check(tx_state == 2'b01, "R10 poll resumes", 32'(tx_state), 1);
    for (int i = 0; i < 20 && start_cnt == n; i++) @(negedge clk);
    check(start_cnt == n + 1, "R10 frame started", 32'(start_cnt), 32'(n + 1));
    check(unavail_flag == 1'b1, "R11 flag sticky", 32'(unavail_flag), 1);
    @(negedge clk); unavail_clr = 1'b1;
    @(negedge clk); unavail_clr = 1'b0;
    check(unavail_flag == 1'b0, "R11 flag cleared", 32'(unavail_flag), 0);
    wr_ctl(8'h18, W_ARM);
    wait_state(2'b00, 200);
    check(tx_state == 2'b00, "R7 halt from running", 32'(tx_state), 0);
    n = req_cnt;
    wr_ctl(8'h18, 32'h0);
    repeat (10) @(negedge clk);
    check(tx_state == 2'b00 && req_cnt == n, "R7 halt while stopped", 32'(tx_state), 0);

    // R6 / R7 / R8: acquisition failure, halt from Suspended, resume
    lat = 1; dly = 2; rearm = 1'b1; own_all(1'b1); err_addr = BASE + 32'd32;
    do_reset();
    wr_ctl(8'h18, W_ARM | W_RUN);
    wait_state(2'b10, 300);
    repeat (4) @(negedge clk);
    check(tx_state == 2'b10, "R6 suspended on error", 32'(tx_state), 2);
    check(unavail_flag == 1'b0, "R6 flag untouched", 32'(unavail_flag), 0);
    check(last_req == BASE + 32'd32, "R6 failed address", last_req, BASE + 32'd32);
    wr_ctl(8'h18, W_ARM);
    wait_state(2'b00, 100);
    check(tx_state == 2'b00, "R7 halt from suspended", 32'(tx_state), 0);
    n = req_cnt;
    wr_ctl(8'h18, W_ARM | W_RUN);
    for (int i = 0; i < 20 && req_cnt == n; i++) @(negedge clk);
    check(last_req == BASE + 32'd32, "R8 resume at saved position", last_req, BASE + 32'd32);

    // R3: run command during a draining halt is ignored
    err_addr = 32'hFFFF_FFFF; lat = 1; dly = 20; cur_ovl = 0;
    do_reset();
    wr_ctl(8'h18, W_ARM | W_RUN);
    for (int i = 0; i < 20 && start_cnt == 0; i++) @(negedge clk);
    wr_ctl(8'h18, W_ARM);
    wr_ctl(8'h18, W_ARM | W_RUN);
    check(tx_state == 2'b01, "R7 frame still draining", 32'(tx_state), 1);
    wait_state(2'b00, 100);
    n = req_cnt;
    repeat (30) @(negedge clk);
    check(tx_state == 2'b00 && req_cnt == n, "R3 run during halt ignored", 32'(tx_state), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule